// File: doc/BRIEF.md
# Conditional Branch and Link Resolver

This combinational unit resolves the control-flow outcome of the branch instructions of a 32-bit load/store processor. It receives the fetched instruction word, the already incremented program counter, the value read from the target register field (the branch destination) and the value read from the test register field (the value the condition looks at). From these it produces a taken flag, the next program counter, a link-write enable and the link value with its destination register index.

Two opcodes are handled. One plain branch opcode covers every condition, and the condition itself sits in the three least significant bits of the word. A second opcode does the same and also saves the return address into the first register field. The saving form writes the link register whatever the condition is, so the "never" condition turns it into a pure save of the return address. Every other opcode passes through: nothing is taken and nothing is linked.

Top module: `brx_branch_unit`

## Requirements
- R1: Opcode 8 (instruction bits 31..27) is the plain branch. For it `link_we` is low under every condition code.
- R2: Opcode 9 is the saving branch. For it `link_we` is high under every condition code, including "never" and the codes 6 and 7. `link_data` equals `pc_inc`, and `link_reg` equals instruction bits 26..22.
- R3: The condition code is instruction bits 2..0. Code 0 ("never") is never taken and code 1 ("always") is always taken.
- R4: Code 2 is taken exactly when `test_val` is zero. Code 3 is taken exactly when `test_val` is non-zero.
- R5: Code 4 is taken exactly when the sign bit of `test_val` is clear. Code 5 is taken exactly when that sign bit is set.
- R6: Codes 6 and 7 are never taken for either branch opcode.
- R7: When `taken` is high, `next_pc` equals `target_val`. Otherwise `next_pc` equals `pc_inc`.
- R8: For any opcode other than 8 or 9, `taken` and `link_we` are both low and `next_pc` equals `pc_inc`, whatever the other fields hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word under execution |
| pc_inc | input | 32 | Address of the next sequential instruction |
| target_val | input | 32 | Contents of the target register field (destination) |
| test_val | input | 32 | Contents of the test register field (condition operand) |
| taken | output | 1 | High when the branch redirects control flow |
| next_pc | output | 32 | Address the program counter loads next |
| link_we | output | 1 | Write enable for the link register |
| link_reg | output | 5 | Index of the register that receives the link value |
| link_data | output | 32 | Return address to write into the link register |

## Verification
The bench aims at the sign boundary of the test value. It uses zero, the most negative value, the most positive value and minus one. A design that tested two's-complement sign the wrong way, or that treated zero as negative, would take the plus/minus codes on the wrong side of these values. It runs the saving opcode under the "never" and reserved codes, where a design that gated the link write with `taken` would drop the return address. It also sends opcodes next to 8 and 9, and instructions whose low bits encode "always" under a non-branch opcode, so that a loose opcode compare shows up as a spurious jump or link.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int unsigned OPC_W  = 5;
  localparam int unsigned COND_W = 3;
  localparam int unsigned REG_W  = 5;

  localparam logic [OPC_W-1:0] OPC_BR  = 5'd8;
  localparam logic [OPC_W-1:0] OPC_BRL = 5'd9;

  typedef enum logic [COND_W-1:0] {
    CC_NEVER   = 3'd0,
    CC_ALWAYS  = 3'd1,
    CC_ZERO    = 3'd2,
    CC_NONZERO = 3'd3,
    CC_PLUS    = 3'd4,
    CC_MINUS   = 3'd5,
    CC_RSV6    = 3'd6,
    CC_RSV7    = 3'd7
  } cond_e;
endpackage

// File: rtl/brx_opdecode.sv
module brx_opdecode
  import brx_pkg::*;
#(
  parameter int unsigned INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               is_branch,
  output logic               is_link,
  output cond_e              cond,
  output logic [REG_W-1:0]   link_reg
);
  localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
  localparam int unsigned RA_LSB  = OPC_LSB - REG_W;

  logic [OPC_W-1:0] opc;

  always_comb begin
    opc       = instr[INSTR_W-1:OPC_LSB];
    is_link   = (opc == OPC_BRL);
    is_branch = (opc == OPC_BR) || is_link;
    cond      = cond_e'(instr[COND_W-1:0]);
    link_reg  = instr[OPC_LSB-1:RA_LSB];
  end
endmodule

// File: rtl/brx_cond_eval.sv
module brx_cond_eval
  import brx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  cond_e             cond,
  input  logic [DATA_W-1:0] test_val,
  output logic              hit
);
  logic is_zero;
  logic is_neg;

  always_comb begin
    is_zero = (test_val == '0);
    is_neg  = test_val[DATA_W-1];
    unique case (cond)
      CC_ALWAYS:  hit = 1'b1;
      CC_ZERO:    hit = is_zero;
      CC_NONZERO: hit = !is_zero;
      CC_PLUS:    hit = !is_neg;
      CC_MINUS:   hit = is_neg;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/brx_target_mux.sv
module brx_target_mux #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              take,
  input  logic [DATA_W-1:0] target_val,
  input  logic [DATA_W-1:0] pc_inc,
  output logic [DATA_W-1:0] next_pc
);
  always_comb begin
    next_pc = take ? target_val : pc_inc;
  end
endmodule

// File: rtl/brx_branch_unit.sv
module brx_branch_unit
  import brx_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  pc_inc,
  input  logic [DATA_W-1:0]  target_val,
  input  logic [DATA_W-1:0]  test_val,
  output logic               taken,
  output logic [DATA_W-1:0]  next_pc,
  output logic               link_we,
  output logic [REG_W-1:0]   link_reg,
  output logic [DATA_W-1:0]  link_data
);
  logic  is_branch;
  logic  is_link;
  cond_e cond;
  logic  cond_hit;

  brx_opdecode #(.INSTR_W(INSTR_W)) u_dec (
    .instr     (instr),
    .is_branch (is_branch),
    .is_link   (is_link),
    .cond      (cond),
    .link_reg  (link_reg)
  );

  brx_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .cond     (cond),
    .test_val (test_val),
    .hit      (cond_hit)
  );

  always_comb begin
    taken     = is_branch && cond_hit;
    link_we   = is_link;
    link_data = pc_inc;
  end

  brx_target_mux #(.DATA_W(DATA_W)) u_mux (
    .take       (taken),
    .target_val (target_val),
    .pc_inc     (pc_inc),
    .next_pc    (next_pc)
  );

  // Checks across the decoder, evaluator and mux outputs.
  always_comb begin
    if (!$isunknown({instr, pc_inc, target_val, test_val})) begin
      p_link_only_saving_op_r1: assert (!link_we || instr[INSTR_W-1 -: OPC_W] == OPC_BRL);
      p_never_not_taken_r3: assert (!(cond == CC_NEVER && taken));
      p_reserved_not_taken_r6: assert (!((cond == CC_RSV6 || cond == CC_RSV7) && taken));
      p_zero_cond_r4: assert (!(taken && cond == CC_ZERO) || test_val == '0);
      p_minus_cond_r5: assert (!(taken && cond == CC_MINUS) || test_val[DATA_W-1]);
      p_next_pc_sel_r7: assert (next_pc == (taken ? target_val : pc_inc));
      p_other_op_quiet_r8: assert (is_branch || (!taken && !link_we));
    end
  end
endmodule

// File: tb/test_brx_branch_unit.sv
module test_brx_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr, pc_inc, target_val, test_val;
  logic        taken, link_we;
  logic [31:0] next_pc, link_data;
  logic [4:0]  link_reg;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  brx_branch_unit i_brx_branch_unit (
    .instr(instr), .pc_inc(pc_inc), .target_val(target_val), .test_val(test_val),
    .taken(taken), .next_pc(next_pc), .link_we(link_we),
    .link_reg(link_reg), .link_data(link_data)
  );

  function automatic bit exp_taken(logic [31:0] iw, logic [31:0] tv);
    logic [4:0] op = iw[31:27];
    if (op != 5'd8 && op != 5'd9) return 1'b0;
    case (iw[2:0])
      3'd1: return 1'b1;
      3'd2: return tv == 32'd0;
      3'd3: return tv != 32'd0;
      3'd4: return tv[31] == 1'b0;
      3'd5: return tv[31] == 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s instr=%h test=%h act=%h exp=%h", req, instr, test_val, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] iw, logic [31:0] pc, logic [31:0] tg, logic [31:0] tv);
    bit t;
    bit lk;
    string rq;
    @(negedge clk);
    instr = iw; pc_inc = pc; target_val = tg; test_val = tv;
    #2;
    t  = exp_taken(iw, tv);
    lk = (iw[31:27] == 5'd9);
    case (iw[2:0])
      3'd0, 3'd1: rq = "R3";
      3'd2, 3'd3: rq = "R4";
      3'd4, 3'd5: rq = "R5";
      default:    rq = "R6";
    endcase
    if (iw[31:27] != 5'd8 && iw[31:27] != 5'd9) rq = "R8";
    chk(rq, {31'd0, taken}, {31'd0, t});
    chk("R7", next_pc, t ? tg : pc);
    chk(lk ? "R2" : (rq == "R8" ? "R8" : "R1"), {31'd0, link_we}, {31'd0, lk});
    if (lk) begin
      chk("R2", link_data, pc);
      chk("R2", {27'd0, link_reg}, {27'd0, iw[26:22]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] tvals [5];
    tvals[0] = 32'h0000_0000; tvals[1] = 32'h0000_0005; tvals[2] = 32'h8000_0000;
    tvals[3] = 32'hFFFF_FFFF; tvals[4] = 32'h7FFF_FFFF;
    rst_n = 1'b0;
    instr = 32'd0; pc_inc = 32'h0000_0404; target_val = 32'h0000_1000; test_val = 32'd0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R8", {31'd0, taken}, 32'd0);
    chk("R8", next_pc, 32'h0000_0404);
    chk("R8", {31'd0, link_we}, 32'd0);

    // Directed sweep: both opcodes, every condition code, boundary test values
    for (int op = 8; op <= 9; op++)
      for (int cc = 0; cc < 8; cc++)
        for (int k = 0; k < 5; k++)
          apply({op[4:0], 5'd3 + 5'(cc), 5'd4, 5'd5, 9'd0, 3'(cc)},
                32'h0000_0190 + 32'(cc * 4), 32'hCAFE_0000 + 32'(k), tvals[k]);

    // Neighbour opcodes carrying an "always" condition (R8)
    for (int op = 0; op < 32; op++)
      if (op != 8 && op != 9)
        apply({op[4:0], 5'd1, 5'd2, 5'd3, 9'd0, 3'd1}, 32'h0000_2000, 32'hDEAD_BEEC, 32'd0);

    // Constrained random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      logic [31:0] iw = $urandom;
      logic [31:0] tv = $urandom;
      case ($urandom % 4)
        0: iw[31:27] = 5'd8;
        1: iw[31:27] = 5'd9;
        default: ;
      endcase
      case ($urandom % 4)
        0: tv = 32'd0;
        1: tv = {1'b1, tv[30:0]};
        default: ;
      endcase
      apply(iw, $urandom, $urandom, tv);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule